// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder with Compressed Test Mode

This block models the device-side control of an extended-data-out DRAM on a synchronous clock. The active-low strobes `ras_n`, `cas_n`, `we_n` and `oe_n` are sampled every clock, and edges are found by comparing each sample with the one before it. On every RAS falling edge the block sorts the cycle into one of four kinds from the CAS and WE levels: a row access, a RAS-only refresh, a counter-based refresh, or a test-mode entry. A small parameterised array stands in for the cell matrix. The block decodes only a few low address bits for the row and the column.

Counter-based refreshes step an 11-bit refresh row counter. The counter value is shown on `ref_row`. In test mode the block compresses a 4x4 patch of cells. A write puts one data bit into every cell of the patch. A read reports with one flag whether all 16 cells of the patch hold the same value. The output driver enable follows the EDO rules. It turns on with a read CAS fall. It holds the data after CAS rises. It turns off when RAS rises, when OE rises, or when WE falls.

Top module: `edo_dram_core`

## Requirements
- R1: When RAS falls with CAS high, the block opens an access cycle and latches the row from `addr[ROW_AW-1:0]`. The upper address bits are ignored. Each CAS fall inside that cycle latches a column from `addr[COL_AW-1:0]`, so several columns of one row can be reached in a single RAS cycle.
- R2: A CAS fall with WE low (early write) stores `dq_in` in the addressed cell. A CAS fall with WE high reads the cell, and its value appears on `dq_out` one clock after the fall is sampled.
- R3: The refresh counter `ref_row` resets to 0. It advances by one on each RAS fall that finds CAS low, wraps from 2047 to 0, and does not depend on `addr`. Access cycles and RAS-only refreshes leave it unchanged.
- R4: When WE falls while CAS is held low in an access cycle (late write or read-modify-write), `dq_in` is stored at the column latched at the CAS fall.
- R5: A RAS fall with CAS and WE both low sets `test_mode` and also advances `ref_row`.
- R6: In test mode a write stores `{4{dq_in[0]}}` into the four columns that match the column address on all bits above bit 1. Column bits 0 and 1 are ignored. No other cell changes.
- R7: In test mode a read drives `dq_out` = 4'b1111 when all 16 cells of the addressed patch are equal, and 4'b0000 when any of them differs. Column bits 0 and 1 are ignored.
- R8: A RAS fall with CAS low and WE high clears `test_mode`. A RAS-only refresh (RAS low, then high, with no CAS fall between) also clears it. A further test-entry cycle leaves it set.
- R9: `dq_oe` turns on after a CAS fall in an access cycle with OE low and WE high. It stays on, and `dq_out` keeps its value, after CAS rises.
- R10: `dq_oe` is 0 one clock after any edge that samples RAS high, OE high or WE low. A write cycle never turns it on.
- R11: After reset, `dq_oe`, `test_mode`, `ref_row` and `dq_out` are 0 and every cell reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (11) | Multiplexed row/column address |
| dq_in | input | DW (4) | Write data |
| dq_out | output | DW (4) | Read data or test flag, held EDO-style |
| dq_oe | output | 1 | Data driver enable |
| ref_row | output | REF_W (11) | Internal refresh row counter |
| test_mode | output | 1 | Compressed test mode is active |

## Verification
Every cell of the default 8x8 array is written with a computed pattern and read back, with junk on the unused row bits. A decoder that used the wrong address bits would therefore alias cells. Several cases target the strobe-order decode: a plain counter refresh, a repeated test entry, and a RAS-only refresh that must end test mode. A design that mixed up the WE level at RAS fall, or missed that no CAS fall came, would leave `test_mode` in the wrong state. The compressed path is checked in four ways: a mismatching patch, a patch that a test write has just made uniform, a single changed cell, and column bits 0 and 1 set to odd values. These catch a comparator that looks at only one column, and a write that spills outside its patch. The bench also covers the late-write, driver turn-off and counter-wrap cases, where a design would keep the bus driven or count past 2047.

// File: rtl/edo_dram_pkg.sv
// Shared types for the EDO DRAM cycle decoder.
package edo_dram_pkg;
    // Kind of RAS cycle in progress, chosen at RAS fall
    typedef enum logic [1:0] {
        CY_IDLE    = 2'd0,
        CY_ACCESS  = 2'd1,
        CY_REFRESH = 2'd2
    } cycle_e;
endpackage

// File: rtl/strobe_edges.sv
// Registers the strobe samples and reports falling and rising edges.
// Assumes all strobes idle high (inactive) during reset.
module strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic we_fall
);
    logic ras_prev, cas_prev, we_prev;

    // Hold the previous sample of each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
            we_prev  <= 1'b1;
        end else begin
            ras_prev <= ras_n;
            cas_prev <= cas_n;
            we_prev  <= we_n;
        end
    end

    // High-to-low or low-to-high between consecutive samples
    always_comb begin
        ras_fall = ras_prev & ~ras_n;
        ras_rise = ~ras_prev & ras_n;
        cas_fall = cas_prev & ~cas_n;
        we_fall  = we_prev & ~we_n;
    end
endmodule

// File: rtl/cycle_decoder.sv
// Classifies each RAS cycle from CAS/WE at RAS fall, latches row and
// column, runs the refresh counter and the test-mode flag.
// Assumes CAS falls at least one clock after RAS in an access cycle.
module cycle_decoder
    import edo_dram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int ROW_AW = 3,
    parameter int COL_AW = 3,
    parameter int REF_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_AW-1:0] row_q,
    output logic [COL_AW-1:0] col_q,
    output logic [REF_W-1:0]  ref_row,
    output logic              test_mode,
    output logic              acc_active
);
    cycle_e kind;
    logic   cas_seen;

    // Cycle classification, address latches, refresh counter, test flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind      <= CY_IDLE;
            cas_seen  <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            ref_row   <= '0;
            test_mode <= 1'b0;
        end else if (ras_fall) begin
            if (cas_n) begin
                kind     <= CY_ACCESS;
                row_q    <= addr[ROW_AW-1:0];
                cas_seen <= 1'b0;
            end else begin
                kind      <= CY_REFRESH;
                ref_row   <= ref_row + 1'b1;
                test_mode <= ~we_n;
            end
        end else if (ras_rise) begin
            if (kind == CY_ACCESS && !cas_seen)
                test_mode <= 1'b0;
            kind <= CY_IDLE;
        end else if (kind == CY_ACCESS && cas_fall && !ras_n) begin
            cas_seen <= 1'b1;
            col_q    <= addr[COL_AW-1:0];
        end
    end

    // Array accesses are allowed only while an access cycle holds RAS low
    assign acc_active = (kind == CY_ACCESS) && !ras_n;
endmodule

// File: rtl/cell_array.sv
// Small cell matrix with normal and compressed (test-mode) access.
// Test mode groups the four columns that differ only in bits 1:0.
module cell_array #(
    parameter int ROW_AW = 3,
    parameter int COL_AW = 3,
    parameter int DW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_active,
    input  logic              test_mode,
    input  logic              cas_fall,
    input  logic              we_fall,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ROW_AW-1:0] row,
    input  logic [COL_AW-1:0] col_addr,
    input  logic [COL_AW-1:0] col_q,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out
);
    localparam int IDX_W = ROW_AW + COL_AW;
    localparam int DEPTH = 1 << IDX_W;
    localparam int GRP   = 4;

    logic [DW-1:0]     mem [DEPTH];
    logic [COL_AW-1:0] col_sel;
    logic [IDX_W-1:0]  idx;
    logic [DW-1:0]     grp_cell [GRP];
    logic [GRP-1:0]    grp_ok;
    logic              wr_en, rd_en, agree;

    // Column comes from the pins on CAS fall, else from the latch
    always_comb begin
        col_sel = cas_fall ? col_addr : col_q;
        idx     = {row, col_sel};
        wr_en   = acc_active & ((cas_fall & ~we_n) | (we_fall & ~cas_n));
        rd_en   = acc_active & cas_fall & we_n;
    end

    // One comparator per column of the compressed patch
    for (genvar g = 0; g < GRP; g++) begin : g_grp
        assign grp_cell[g] = mem[{row, col_sel[COL_AW-1:2], 2'(g)}];
        assign grp_ok[g]   = (grp_cell[g] == {DW{grp_cell[0][0]}});
    end
    assign agree = &grp_ok;

    // Cell writes (single or patch) and the EDO output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            dq_out <= '0;
        end else begin
            if (wr_en) begin
                if (test_mode) begin
                    for (int g = 0; g < GRP; g++)
                        mem[{row, col_sel[COL_AW-1:2], 2'(g)}] <= {DW{dq_in[0]}};
                end else begin
                    mem[idx] <= dq_in;
                end
            end
            if (rd_en)
                dq_out <= test_mode ? {DW{agree}} : mem[idx];
        end
    end
endmodule

// File: rtl/out_enable.sv
// Data driver enable with extended-data-out hold.
// Turns on at a read CAS fall; CAS rising does not turn it off.
module out_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_active,
    input  logic cas_fall,
    input  logic ras_n,
    input  logic oe_n,
    input  logic we_n,
    output logic dq_oe
);
    logic set_en, clr_en;

    // Turn-on and turn-off conditions
    always_comb begin
        clr_en = ras_n | oe_n | ~we_n;
        set_en = acc_active & cas_fall & ~oe_n & we_n;
    end

    // Enable register, turn-off has priority
    always_ff @(posedge clk) begin
        if (!rst_n)      dq_oe <= 1'b0;
        else if (clr_en) dq_oe <= 1'b0;
        else if (set_en) dq_oe <= 1'b1;
    end
endmodule

// File: rtl/edo_dram_core.sv
// EDO DRAM control model: strobe edge detection, cycle decode with
// refresh and test-mode commands, small cell array, output enable.
// Assumes COL_AW >= 2 and COL_AW <= ROW_AW < ADDR_W.
module edo_dram_core #(
    parameter int ADDR_W = 11,
    parameter int ROW_AW = 3,
    parameter int COL_AW = 3,
    parameter int DW     = 4,
    parameter int REF_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic [REF_W-1:0]  ref_row,
    output logic              test_mode
);
    logic              ras_fall, ras_rise, cas_fall, we_fall;
    logic              acc_active;
    logic [ROW_AW-1:0] row_q;
    logic [COL_AW-1:0] col_q;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:ROW_AW];

    strobe_edges i_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall)
    );

    cycle_decoder #(
        .ADDR_W(ADDR_W), .ROW_AW(ROW_AW), .COL_AW(COL_AW), .REF_W(REF_W)
    ) i_decode (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
        .addr(addr), .row_q(row_q), .col_q(col_q), .ref_row(ref_row),
        .test_mode(test_mode), .acc_active(acc_active)
    );

    cell_array #(
        .ROW_AW(ROW_AW), .COL_AW(COL_AW), .DW(DW)
    ) i_cells (
        .clk(clk), .rst_n(rst_n), .acc_active(acc_active), .test_mode(test_mode),
        .cas_fall(cas_fall), .we_fall(we_fall), .cas_n(cas_n), .we_n(we_n),
        .row(row_q), .col_addr(addr[COL_AW-1:0]), .col_q(col_q),
        .dq_in(dq_in), .dq_out(dq_out)
    );

    out_enable i_oe (
        .clk(clk), .rst_n(rst_n), .acc_active(acc_active), .cas_fall(cas_fall),
        .ras_n(ras_n), .oe_n(oe_n), .we_n(we_n), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/edo_dram_core_chk.sv
// Protocol checker for edo_dram_core, attached with bind.
module edo_dram_core_chk #(
    parameter int REF_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe,
    input logic [REF_W-1:0] ref_row,
    input logic             test_mode
);
    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n) && !ras_n && !cas_n) |=> (ref_row == REF_W'($past(ref_row) + 1'b1))); // R3
    AST_REF_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n) && !ras_n && cas_n) |=> $stable(ref_row)); // R3
    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n) && !ras_n && !cas_n && !we_n) |=> test_mode); // R5
    AST_TEST_EXIT_CBR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n) && !ras_n && !cas_n && we_n) |=> !test_mode); // R8
    AST_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n || oe_n || !we_n) |=> !dq_oe); // R10
    AST_DRV_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(!cas_n) && $past(!oe_n) && $past(we_n))); // R9
endmodule

bind edo_dram_core edo_dram_core_chk #(.REF_W(REF_W)) i_chk (.*);

// File: tb/test_edo_dram_core.sv
module test_edo_dram_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out;
    logic        dq_oe;
    logic [10:0] ref_row;
    logic        test_mode;
    int          checks = 0, failures = 0;
    int          exp_ref = 0;
    bit          done = 1'b0;

    edo_dram_core i_edo_dram_core (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .ref_row(ref_row), .test_mode(test_mode)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] pat(input int r, input int c);
        return 4'(r * 3 + c * 5 + 1);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ras_open(input int row);
        cas_n = 1'b1; addr = {8'(row * 37), 3'(row)}; ras_n = 1'b0; tick();
    endtask

    task automatic ras_close();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
    endtask

    task automatic wr(input int col, input logic [3:0] d);
        addr = 11'(col); dq_in = d; we_n = 1'b0; cas_n = 1'b0; tick();
        cas_n = 1'b1; we_n = 1'b1; tick();
    endtask

    // Read: leaves CAS low for one sample, then raises it
    task automatic rd(input int col, input string req, input logic [3:0] exp);
        addr = 11'(col); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; tick();
        check(req, 11'(dq_out), 11'(exp));
        cas_n = 1'b1; tick();
    endtask

    task automatic cbr(input logic we);
        cas_n = 1'b0; we_n = we; addr = 11'h7FF; tick();
        ras_n = 1'b0; tick();
        ras_n = 1'b1; tick();
        cas_n = 1'b1; we_n = 1'b1; tick();
        exp_ref = (exp_ref + 1) % 2048;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1; tick();
        // R11: reset state
        check("R11 dq_oe", 11'(dq_oe), 0);
        check("R11 test_mode", 11'(test_mode), 0);
        check("R11 ref_row", ref_row, 0);
        check("R11 dq_out", 11'(dq_out), 0);
        ras_open(5); rd(2, "R11 cell", 4'h0); ras_close();

        // R1 R2: page-mode write sweep then read-back of every cell
        for (int r = 0; r < 8; r++) begin
            ras_open(r);
            for (int c = 0; c < 8; c++) wr(c, pat(r, c));
            ras_close();
        end
        for (int r = 0; r < 8; r++) begin
            ras_open(r);
            for (int c = 0; c < 8; c++) rd(c, "R1 R2 sweep", pat(r, c));
            ras_close();
        end

        // R10: early write with OE low never drives
        ras_open(4);
        oe_n = 1'b0; addr = 11'd3; dq_in = pat(4, 3); we_n = 1'b0; cas_n = 1'b0; tick();
        check("R10 write no drive", 11'(dq_oe), 0);
        cas_n = 1'b1; we_n = 1'b1; tick();
        ras_close();

        // R9: EDO hold after CAS rises; R10: OE high turns off
        ras_open(1);
        addr = 11'd0; oe_n = 1'b0; cas_n = 1'b0; tick();
        check("R9 drive on", 11'(dq_oe), 1);
        cas_n = 1'b1; tick();
        check("R9 drive held", 11'(dq_oe), 1);
        check("R9 data held", 11'(dq_out), 11'(pat(1, 0)));
        oe_n = 1'b1; tick();
        check("R10 oe off", 11'(dq_oe), 0);
        ras_close();

        // R10: RAS high turns off
        ras_open(1);
        addr = 11'd1; oe_n = 1'b0; cas_n = 1'b0; tick();
        cas_n = 1'b1; tick();
        ras_n = 1'b1; tick();
        check("R10 ras off", 11'(dq_oe), 0);
        oe_n = 1'b1; tick();

        // R4: read-modify-write, R10: WE low turns off
        ras_open(1);
        addr = 11'd2; oe_n = 1'b0; cas_n = 1'b0; tick();
        check("R4 rmw read", 11'(dq_out), 11'(pat(1, 2)));
        addr = 11'd7; dq_in = 4'h9; we_n = 1'b0; tick();
        check("R10 we off", 11'(dq_oe), 0);
        we_n = 1'b1; cas_n = 1'b1; tick();
        ras_close();
        ras_open(1); rd(2, "R4 late write stored", 4'h9); rd(7, "R4 other col", pat(1, 7)); ras_close();

        // R3: counter refresh, address ignored; RAS-only leaves counter
        cbr(1'b1);
        check("R3 cbr step", ref_row, 11'(exp_ref));
        check("R8 cbr no test", 11'(test_mode), 0);
        ras_open(3); ras_close();
        check("R3 ras-only hold", ref_row, 11'(exp_ref));

        // R5: test entry
        cbr(1'b0);
        check("R5 entry", 11'(test_mode), 1);
        check("R5 entry refresh", ref_row, 11'(exp_ref));

        // R6 R7: compressed write then compare
        ras_open(2);
        wr(6, 4'b0001);
        rd(4, "R7 uniform patch", 4'hF);
        rd(1, "R7 mismatch patch", 4'h0);
        ras_close();
        cbr(1'b0);
        check("R8 re-entry keeps", 11'(test_mode), 1);
        cbr(1'b1);
        check("R8 cbr exit", 11'(test_mode), 0);
        check("R3 count", ref_row, 11'(exp_ref));
        ras_open(2);
        for (int c = 0; c < 8; c++)
            rd(c, "R6 patch fill", (c >= 4) ? 4'hF : pat(2, c));
        wr(5, 4'hE);
        ras_close();

        cbr(1'b0);
        ras_open(2);
        rd(7, "R7 one cell differs", 4'h0);
        wr(5, 4'b1110);
        rd(4, "R7 patch cleared", 4'hF);
        ras_close();
        ras_open(0); ras_close();
        check("R8 ras-only exit", 11'(test_mode), 0);
        ras_open(2); rd(6, "R6 zero fill", 4'h0); rd(3, "R6 outside patch", pat(2, 3)); ras_close();

        // R3: wrap of the refresh counter
        while (exp_ref != 2047) cbr(1'b1);
        check("R3 reach max", ref_row, 11'd2047);
        cbr(1'b1);
        check("R3 wrap", ref_row, 11'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule